// File: doc/BRIEF.md
# Total Power Integration Sequencer

This block sets the integrate-and-dump cadence for a bank of total power detector channels. A period counter on the system clock issues a dump every `CLK_PER_DUMP` cycles (50,000 cycles at 25 MHz gives 2 ms). A strobe pulse of `STROBE_LEN` cycles (32 cycles, 1.28 us) follows each dump. A slow timing reference is synchronized and its rising edge forces an immediate dump with a counter restart. This keeps the cadence phase-locked to the reference: a 48 ms reference period holds exactly 24 dumps. If a reference edge arrives well away from the point where the counter would wrap anyway, a sticky slip flag records it.

Every channel sums its valid-qualified samples into a saturating accumulator. On a dump, each accumulator is copied into a holding register and restarts in that same cycle. A sample presented in the dump cycle becomes the first term of the new sum. A monitor host then pulls the held results one byte at a time through a simple read-advance interface.

Top module: `tpi_sequencer`

## Requirements
- R1: After reset, `strobe_o`, `ready_o` and `slip_o` are 0, `ovf_o` is all zeros and `rd_data_o` is 0x00.
- R2: With no reference edge, successive rising edges of `strobe_o` are exactly `CLK_PER_DUMP` clock cycles apart.
- R3: `strobe_o` rises in the cycle after the dump edge and stays high for exactly `STROBE_LEN` cycles.
- R4: A rising edge on `ref_i` passes through `SYNC_STAGES` flops and an edge detector. With 2 stages, when `ref_i` is set up before clock edge k, the forced dump happens on edge k+2 and `strobe_o` is high after it. The counter restarts, so the next dump is `CLK_PER_DUMP` cycles later.
- R5: With the reference period equal to 24 dump periods and aligned to the natural wrap, exactly 24 strobes occur per reference period.
- R6: `slip_o` is set when a reference edge finds the counter more than `SLIP_TOL` cycles from its wrap point on both sides. Here the distance is min(`CLK_PER_DUMP`-1-count, count+1). A distance of exactly `SLIP_TOL` does not set it. It clears when the last readout byte is read.
- R7: Each accumulator adds only samples whose valid bit is 1. A dump copies the sum to the holding register. A valid sample in the dump cycle starts the next sum, so a valid stream of constant v gives exactly `CLK_PER_DUMP`·v per dump.
- R8: An accumulator saturates at 2^`ACC_W`-1 instead of wrapping. It then sets its bit in `ovf_o`, and that bit stays set until the last readout byte is read.
- R9: Readout byte i (0 to `NCH`·`ACC_W`/8-1) is taken from channel i/(`ACC_W`/8). Within a channel the bytes run most significant first, so with `ACC_W`=24, i%3=0 is bits 23:16 and i%3=2 is bits 7:0. `rd_data_o` shows the current byte, and `rd_i` while ready advances to the next one.
- R10: Each dump sets `ready_o` and points the readout at byte 0. The read that consumes the last byte clears `ready_o` and returns the pointer to byte 0.
- R11: A read asserted while `ready_o` is 0 is ignored, and `rd_data_o` keeps showing byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Asynchronous slow timing reference |
| smp_valid_i | input | NCH | Per-channel sample qualifier |
| smp_data_i | input | NCH·SAMPLE_W | Unsigned detector samples, channel 0 in the low bits |
| rd_i | input | 1 | Consume the current readout byte |
| rd_data_o | output | 8 | Current readout byte |
| ready_o | output | 1 | A dumped result set is waiting to be read |
| strobe_o | output | 1 | Integration timing strobe |
| slip_o | output | 1 | Sticky flag for a reference edge that arrived off-phase |
| ovf_o | output | NCH | Sticky per-channel saturation flags |

## Verification
A sample is visible in the held result only after the next dump edge. `ready_o` and the strobe change on that edge, while a reference rise shows up at the strobe on the third clock edge. A read advances `rd_data_o` one edge after `rd_i`. The bench locates each dump by catching the strobe's rising edge at a falling clock edge, then counts falling edges from there. It drives stimulus and samples outputs only on those falling edges, so each comparison lands one half-cycle after the edge where the result is due. All expected sums, saturation values, byte slices and strobe positions are computed in the bench from the period, the strobe length and the sample values.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

   localparam int BYTE_W = 8;

   // True when a position lies further than tol cycles from the wrap point
   // on both the early and the late side.
   function automatic logic tpi_far(input int pos, input int period, input int tol);
      return ((period - 1 - pos) > tol) && ((pos + 1) > tol);
   endfunction

endpackage

// File: rtl/tpi_ref_sync.sv
module tpi_ref_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_i,
   output logic edge_o
);

   logic [STAGES-1:0] chain_q;
   logic              seen_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chain_q <= '0;
         seen_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], ref_i};
         seen_q  <= chain_q[STAGES-1];
      end
   end

   assign edge_o = chain_q[STAGES-1] & ~seen_q;

   // R4
   ref_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |=> !edge_o);

endmodule

// File: rtl/tpi_cadence.sv
module tpi_cadence import tpi_pkg::*; #(
   parameter int PERIOD     = 50000,
   parameter int STROBE_LEN = 32,
   parameter int SLIP_TOL   = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ref_edge_i,
   input  logic slip_clr_i,
   output logic dump_o,
   output logic strobe_o,
   output logic slip_o
);

   localparam int CNT_W = $clog2(PERIOD);
   localparam int WID_W = $clog2(STROBE_LEN + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [WID_W-1:0] wid_q;
   logic             slip_q;
   logic             far;

   assign dump_o = ref_edge_i || (cnt_q == CNT_W'(PERIOD - 1));
   assign far    = ref_edge_i && tpi_far(int'(cnt_q), PERIOD, SLIP_TOL);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         wid_q  <= '0;
         slip_q <= 1'b0;
      end else begin
         cnt_q <= dump_o ? '0 : cnt_q + 1'b1;
         if (dump_o)
            wid_q <= WID_W'(STROBE_LEN);
         else if (wid_q != '0)
            wid_q <= wid_q - 1'b1;
         if (far)
            slip_q <= 1'b1;
         else if (slip_clr_i)
            slip_q <= 1'b0;
      end
   end

   assign strobe_o = (wid_q != '0);
   assign slip_o   = slip_q;

   // R4
   ref_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_edge_i |=> (cnt_q == '0));
   // R3
   strobe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dump_o |=> strobe_o);
   // R6
   slip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(slip_o) |-> $past(ref_edge_i));

endmodule

// File: rtl/tpi_accum.sv
module tpi_accum #(
   parameter int SAMPLE_W = 16,
   parameter int ACC_W    = 24
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                dump_i,
   input  logic                valid_i,
   input  logic [SAMPLE_W-1:0] data_i,
   input  logic                ovf_clr_i,
   output logic [ACC_W-1:0]    hold_o,
   output logic                ovf_o
);

   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   logic [ACC_W-1:0] acc_q, hold_q;
   logic             ovf_q;
   logic [ACC_W:0]   sum;
   logic             carry;

   assign sum   = {1'b0, acc_q} + (ACC_W+1)'(data_i);
   assign carry = sum[ACC_W];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         hold_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (dump_i) begin
            hold_q <= acc_q;
            acc_q  <= valid_i ? ACC_W'(data_i) : '0;
         end else if (valid_i) begin
            acc_q <= carry ? ACC_MAX : sum[ACC_W-1:0];
         end
         if (valid_i && !dump_i && carry)
            ovf_q <= 1'b1;
         else if (ovf_clr_i)
            ovf_q <= 1'b0;
      end
   end

   assign hold_o = hold_q;
   assign ovf_o  = ovf_q;

   // R8
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dump_i |=> (acc_q >= $past(acc_q)));
   // R8
   ovf_at_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ovf_o) |-> (acc_q == ACC_MAX));
   // R7
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i && !dump_i) |=> $stable(acc_q));

endmodule

// File: rtl/tpi_readout.sv
module tpi_readout import tpi_pkg::*; #(
   parameter int NCH   = 6,
   parameter int ACC_W = 24
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 dump_i,
   input  logic                 rd_i,
   input  logic [NCH*ACC_W-1:0] hold_i,
   output logic [BYTE_W-1:0]    data_o,
   output logic                 ready_o,
   output logic                 last_rd_o
);

   localparam int BPC   = ACC_W / BYTE_W;
   localparam int NBYTE = NCH * BPC;
   localparam int PW    = $clog2(NBYTE);
   localparam logic [PW-1:0] LAST = PW'(NBYTE - 1);

   logic [BYTE_W-1:0] byte_arr [NBYTE];
   logic [PW-1:0]     ptr_q;
   logic              ready_q;

   for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
      for (genvar gb = 0; gb < BPC; gb++) begin : g_byte
         assign byte_arr[gc*BPC + gb] = hold_i[gc*ACC_W + ACC_W - 1 - BYTE_W*gb -: BYTE_W];
      end
   end

   assign data_o    = byte_arr[ptr_q];
   assign ready_o   = ready_q;
   assign last_rd_o = rd_i && ready_q && (ptr_q == LAST) && !dump_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ptr_q   <= '0;
         ready_q <= 1'b0;
      end else if (dump_i) begin
         ptr_q   <= '0;
         ready_q <= 1'b1;
      end else if (rd_i && ready_q) begin
         if (ptr_q == LAST) begin
            ptr_q   <= '0;
            ready_q <= 1'b0;
         end else begin
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   // R11
   idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && !dump_i) |=> $stable(ptr_q));
   // R10
   last_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      last_rd_o |=> (!ready_o && ptr_q == '0));
   // R10
   dump_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dump_i |=> (ready_o && ptr_q == '0));

endmodule

// File: rtl/tpi_sequencer.sv
module tpi_sequencer import tpi_pkg::*; #(
   parameter int NCH          = 6,
   parameter int SAMPLE_W     = 16,
   parameter int ACC_W        = 24,
   parameter int CLK_PER_DUMP = 50000,
   parameter int STROBE_LEN   = 32,
   parameter int SLIP_TOL     = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    ref_i,
   input  logic [NCH-1:0]          smp_valid_i,
   input  logic [NCH*SAMPLE_W-1:0] smp_data_i,
   input  logic                    rd_i,
   output logic [BYTE_W-1:0]       rd_data_o,
   output logic                    ready_o,
   output logic                    strobe_o,
   output logic                    slip_o,
   output logic [NCH-1:0]          ovf_o
);

   if (ACC_W % BYTE_W != 0) begin : g_bad_acc
      $error("ACC_W must be a whole number of bytes");
   end
   if (SAMPLE_W > ACC_W) begin : g_bad_smp
      $error("SAMPLE_W must not exceed ACC_W");
   end
   if (STROBE_LEN < 1 || STROBE_LEN >= CLK_PER_DUMP) begin : g_bad_strobe
      $error("STROBE_LEN must lie in 1..CLK_PER_DUMP-1");
   end
   if (2 * SLIP_TOL + 2 > CLK_PER_DUMP) begin : g_bad_tol
      $error("SLIP_TOL too large for CLK_PER_DUMP");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (NCH < 1 || ACC_W < 2 * BYTE_W) begin : g_bad_shape
      $error("readout needs at least two bytes");
   end

   logic                 ref_edge;
   logic                 dump;
   logic                 last_rd;
   logic [NCH*ACC_W-1:0] hold_bus;

   tpi_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ref_i  (ref_i),
      .edge_o (ref_edge)
   );

   tpi_cadence #(
      .PERIOD     (CLK_PER_DUMP),
      .STROBE_LEN (STROBE_LEN),
      .SLIP_TOL   (SLIP_TOL)
   ) u_cad (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ref_edge_i (ref_edge),
      .slip_clr_i (last_rd),
      .dump_o     (dump),
      .strobe_o   (strobe_o),
      .slip_o     (slip_o)
   );

   for (genvar gc = 0; gc < NCH; gc++) begin : g_acc
      tpi_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .dump_i    (dump),
         .valid_i   (smp_valid_i[gc]),
         .data_i    (smp_data_i[gc*SAMPLE_W +: SAMPLE_W]),
         .ovf_clr_i (last_rd),
         .hold_o    (hold_bus[gc*ACC_W +: ACC_W]),
         .ovf_o     (ovf_o[gc])
      );
   end

   tpi_readout #(.NCH(NCH), .ACC_W(ACC_W)) u_rd (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .dump_i    (dump),
      .rd_i      (rd_i),
      .hold_i    (hold_bus),
      .data_o    (rd_data_o),
      .ready_o   (ready_o),
      .last_rd_o (last_rd)
   );

endmodule

// File: tb/tpi_sequencer_test.sv
module tpi_sequencer_test;

   localparam int NCH = 6;
   localparam int SW  = 20;
   localparam int AW  = 24;
   localparam int P   = 40;
   localparam int L   = 4;
   localparam int TOL = 2;
   localparam int NB  = NCH * AW / 8;
   localparam longint AMAX = (64'd1 << AW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_s = 1'b0;
   logic [NCH-1:0]    vld = '0;
   logic [NCH*SW-1:0] dat = '0;
   logic              rd = 1'b0;
   logic [7:0]        rd_data;
   logic              ready, strobe, slip;
   logic [NCH-1:0]    ovf;

   int total = 0;
   int fails = 0;
   logic [AW-1:0] exp_h [NCH];

   always #2.5 clk = ~clk;

   tpi_sequencer #(
      .NCH(NCH), .SAMPLE_W(SW), .ACC_W(AW), .CLK_PER_DUMP(P),
      .STROBE_LEN(L), .SLIP_TOL(TOL), .SYNC_STAGES(2)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .smp_valid_i(vld),
      .smp_data_i(dat), .rd_i(rd), .rd_data_o(rd_data), .ready_o(ready),
      .strobe_o(strobe), .slip_o(slip), .ovf_o(ovf)
   );

   task automatic chk(input string req, input string what, input longint act, input longint expv);
      total++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [AW-1:0] sat(input longint s);
      return (s > AMAX) ? AMAX[AW-1:0] : s[AW-1:0];
   endfunction

   function automatic logic [7:0] exp_byte(input int i);
      return 8'(exp_h[i / 3] >> (8 * (2 - (i % 3))));
   endfunction

   // returns after the falling edge where strobe is first seen high
   task automatic wait_rise(output int n);
      logic p;
      p = strobe;
      n = 0;
      for (int i = 0; i < 4 * P; i++) begin
         @(negedge clk);
         n++;
         if (strobe && !p) return;
         p = strobe;
      end
      chk("R2", "strobe missing", 0, 1);
   endtask

   task automatic read_all(input string req);
      chk("R10", "ready before read", ready, 1);
      for (int i = 0; i < NB; i++) begin
         chk(req, $sformatf("byte %0d", i), rd_data, exp_byte(i));
         rd = 1'b1;
         @(negedge clk);
      end
      rd = 1'b0;
      chk("R10", "ready after last byte", ready, 0);
   endtask

   task automatic set_data(input int c, input int v);
      dat[c*SW +: SW] = SW'(v);
   endtask

   task automatic ref_case(input int m, input logic exp_slip, input string req);
      int n;
      wait_rise(n);
      repeat (m) @(negedge clk);
      ref_s = 1'b1;
      @(negedge clk);
      chk("R4", "strobe one edge after ref", strobe, 0);
      @(negedge clk);
      chk("R4", "strobe two edges after ref", strobe, 0);
      @(negedge clk);
      chk("R4", "strobe three edges after ref", strobe, 1);
      chk(req, "slip after ref edge", slip, exp_slip);
      wait_rise(n);
      chk("R4", "period after forced dump", n, P);
      ref_s = 1'b0;
   endtask

   initial begin
      int n, w, rises;
      logic p;
      repeat (3) @(negedge clk);
      chk("R1", "strobe in reset", strobe, 0);
      chk("R1", "ready in reset", ready, 0);
      chk("R1", "slip in reset", slip, 0);
      chk("R1", "ovf in reset", ovf, 0);
      chk("R1", "data in reset", rd_data, 0);
      rst_n = 1'b1;

      // free-running period and strobe width
      wait_rise(n);
      wait_rise(n);
      chk("R2", "free-running period", n, P);
      wait_rise(n);
      w = 1;
      for (int i = 0; i < 2 * P; i++) begin
         @(negedge clk);
         if (!strobe) break;
         w++;
      end
      chk("R3", "strobe width", w, L);

      // gated window: 10 samples on a channel mask
      wait_rise(n);
      vld = 6'b101101;
      for (int c = 0; c < NCH; c++) set_data(c, 1000 * (c + 1) + 7);
      repeat (10) @(negedge clk);
      vld = '0;
      for (int c = 0; c < NCH; c++)
         exp_h[c] = vld[c] | ((6'b101101 >> c) & 1) ? sat(10 * (1000 * (c + 1) + 7)) : '0;
      wait_rise(n);
      read_all("R9");

      // continuous stream across the dump cycle
      vld = '1;
      for (int c = 0; c < NCH; c++) set_data(c, 17 * c + 3);
      wait_rise(n);
      wait_rise(n);
      vld = '0;
      for (int c = 0; c < NCH; c++) exp_h[c] = sat(longint'(P) * (17 * c + 3));
      read_all("R7");

      // saturation on channel 2
      vld = '1;
      for (int c = 0; c < NCH; c++) set_data(c, c + 1);
      set_data(0, 'h12345);
      set_data(2, 'hFFFFF);
      wait_rise(n);
      wait_rise(n);
      vld = '0;
      chk("R8", "ovf after saturation", ovf, 6'b000100);
      exp_h[0] = sat(longint'(P) * 'h12345);
      exp_h[1] = sat(longint'(P) * 2);
      exp_h[2] = sat(longint'(P) * 'hFFFFF);
      for (int c = 3; c < NCH; c++) exp_h[c] = sat(longint'(P) * (c + 1));
      read_all("R8");
      chk("R8", "ovf cleared by readout", ovf, 0);

      // reads while not ready are ignored
      rd = 1'b1;
      repeat (3) @(negedge clk);
      rd = 1'b0;
      chk("R11", "data after ignored reads", rd_data, exp_byte(0));
      chk("R11", "ready after ignored reads", ready, 0);

      // reference edges at three phases
      repeat (4) @(negedge clk);
      ref_case(P - 3, 1'b0, "R6");
      ref_case(P - 5, 1'b0, "R6");

      // aligned reference of 24 dump periods
      wait_rise(n);
      repeat (P - 3) @(negedge clk);
      ref_s = 1'b1;
      rises = 0;
      p = strobe;
      for (int i = 1; i <= 24 * P + 3; i++) begin
         @(negedge clk);
         if (strobe && !p && i >= 4) rises++;
         if (i == 24 * P + 3) chk("R5", "strobe at second ref edge", strobe && !p, 1);
         p = strobe;
         if (i == 5) ref_s = 1'b0;
         if (i == 24 * P) ref_s = 1'b1;
      end
      chk("R5", "strobes per reference period", rises, 24);
      chk("R6", "no slip when aligned", slip, 0);
      ref_s = 1'b0;
      repeat (4) @(negedge clk);

      ref_case(P - 6, 1'b1, "R6");
      for (int c = 0; c < NCH; c++) exp_h[c] = '0;
      read_all("R9");
      chk("R6", "slip cleared by readout", slip, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(100000 * 5);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule